// File: doc/BRIEF.md
# Fiducial-Triggered Multi-Channel Pulse Delay Generator

This block turns one periodic timing marker into a set of independent trigger pulses, each with its own programmable delay and width. The marker arrives asynchronously on a single input. It is brought into the system clock domain, and its rising edge restarts a cycle counter that all channels share. Each channel compares that counter against its own turn-on and turn-off counts. Its output goes high when the counter reaches the turn-on count and low when it reaches the turn-off count. One comparison against a stored count therefore sets both the delay after the marker and the pulse length.

A host loads the counts through a simple one-cycle write port, one channel per write. Written values go to a holding copy and become live only at the next marker edge. A retune can therefore never cut or stretch a pulse that is already running. With the default 24-bit counter and a 119 MHz system clock, delays of well over 20 µs (about 2380 cycles) are reachable, and a fixed 1 µs pulse is simply a turn-off count 119 above the turn-on count.

Top module: `trig_delay_gen`

## Requirements
- R1: Count the edge at which the synchronizer first samples `fid_in` high as edge 1. A live channel with turn-on count S then rises on rising clock edge S+4 after the marker (two synchronizer flops, one edge-detect flop, one output flop).
- R2: The counter restarts only on a low-to-high transition of the synchronized marker. Holding `fid_in` high for many cycles gives one restart, not one per cycle.
- R3: A live channel with turn-off count P greater than S falls on edge P+4, so its pulse lasts exactly P−S cycles.
- R4: A channel whose turn-off count is less than or equal to its turn-on count keeps its output low.
- R5: A channel whose enable bit is 0 keeps its output low.
- R6: A write with `cfg_we` high loads `cfg_start`, `cfg_stop` and `cfg_en` into the holding copy of channel `cfg_ch`. The live copy takes the holding values only at the next marker edge, so a write during a pulse does not change that pulse.
- R7: The counter stops at its all-ones value instead of wrapping, so each channel fires at most once per marker. A turn-off count equal to the all-ones value still ends the pulse.
- R8: After reset all outputs are low, and no channel fires before the first marker (the counter resets saturated and every channel resets disabled).
- R9: A turn-on count of 0 is legal (rise on edge 4), and with the default width a delay of 2380 cycles followed by a 119-cycle pulse is produced exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fid_in | input | 1 | Asynchronous timing marker |
| cfg_we | input | 1 | Host write strobe, one cycle per channel |
| cfg_ch | input | CH_W (3) | Channel index for the write; indices of NUM_CH or above are ignored |
| cfg_start | input | CNT_W (24) | Turn-on count written to the holding copy |
| cfg_stop | input | CNT_W (24) | Turn-off count written to the holding copy |
| cfg_en | input | 1 | Channel enable written to the holding copy |
| trig_o | output | NUM_CH (8) | Trigger outputs, one bit per channel |

## Verification
The main function is exercised with four full channel sets. Each set mixes zero delay, the 20 µs delay with a 1 µs width, one-cycle pulses, equal and reversed counts, and disabled channels, so an off-by-one in the rise or fall edge is told apart from a wrong range test or a wrong enable. Each following set is written while pulses of the current set are running, which separates shadowed loading from direct loading. A marker held high for 100 cycles distinguishes edge restart from level restart. A narrow-counter instance run far past its all-ones value distinguishes saturation from wrapping, which would show up as a second pulse.

// File: rtl/trig_pkg.sv
package trig_pkg;

   // Index width for a bank of n channels, never narrower than one bit.
   function automatic int trig_idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/trig_fid_sync.sv
module trig_fid_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fid_in,
   output logic fid_pulse
);

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("trig_fid_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] chain_q;
   logic                   prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[SYNC_STAGES-2:0], fid_in};
         prev_q  <= chain_q[SYNC_STAGES-1];
      end
   end

   assign fid_pulse = chain_q[SYNC_STAGES-1] & ~prev_q;

   // R2: a held marker yields a single restart strobe
   p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fid_pulse |=> !fid_pulse);

endmodule

// File: rtl/trig_counter.sv
module trig_counter #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fid_pulse,
   output logic [CNT_W-1:0] cnt_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 2) begin : g_bad_width
      $error("trig_counter: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= CNT_MAX;
      else if (fid_pulse)        cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

   // R1: the marker edge restarts the count at zero
   p_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fid_pulse |=> (cnt_q == '0));

   // R1: between markers the count advances by one per cycle
   p_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!fid_pulse && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

   // R7: the count holds at all-ones instead of wrapping
   p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!fid_pulse && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/trig_channel.sv
module trig_channel #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fid_pulse,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             wr_hit,
   input  logic [CNT_W-1:0] wr_start,
   input  logic [CNT_W-1:0] wr_stop,
   input  logic             wr_en,
   output logic             trig_o
);

   logic [CNT_W-1:0] shd_start_q, shd_stop_q;
   logic             shd_en_q;
   logic [CNT_W-1:0] act_start_q, act_stop_q;
   logic             act_en_q;
   logic             live;
   logic             trig_q;

   // Holding copy, written by the host at any time
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shd_start_q <= '0;
         shd_stop_q  <= '0;
         shd_en_q    <= 1'b0;
      end else if (wr_hit) begin
         shd_start_q <= wr_start;
         shd_stop_q  <= wr_stop;
         shd_en_q    <= wr_en;
      end
   end

   // Live copy, refreshed only at a marker edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_start_q <= '0;
         act_stop_q  <= '0;
         act_en_q    <= 1'b0;
      end else if (fid_pulse) begin
         act_start_q <= shd_start_q;
         act_stop_q  <= shd_stop_q;
         act_en_q    <= shd_en_q;
      end
   end

   assign live = act_en_q && (act_stop_q > act_start_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     trig_q <= 1'b0;
      else if (!live)                 trig_q <= 1'b0;
      else if (cnt_i == act_start_q)  trig_q <= 1'b1;
      else if (cnt_i == act_stop_q)   trig_q <= 1'b0;
   end

   assign trig_o = trig_q;

   // R6: live counts change only at a marker edge
   p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !fid_pulse |=> ($stable(act_start_q) && $stable(act_stop_q) && $stable(act_en_q)));

   // R4: reversed or equal counts keep the output low
   p_bad_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (act_stop_q <= act_start_q) |=> !trig_q);

   // R5: a disabled channel keeps the output low
   p_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !act_en_q |=> !trig_q);

   // R1: a rise happens only where the count met the turn-on value
   p_rise_at_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(trig_q) && !$past(fid_pulse)) |-> ($past(cnt_i) == act_start_q));

endmodule

// File: rtl/trig_delay_gen.sv
module trig_delay_gen #(
   parameter int NUM_CH      = 8,
   parameter int CNT_W       = 24,
   parameter int SYNC_STAGES = 2,
   parameter int CH_W        = trig_pkg::trig_idx_w(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fid_in,
   input  logic              cfg_we,
   input  logic [CH_W-1:0]   cfg_ch,
   input  logic [CNT_W-1:0]  cfg_start,
   input  logic [CNT_W-1:0]  cfg_stop,
   input  logic              cfg_en,
   output logic [NUM_CH-1:0] trig_o
);

   if (NUM_CH < 1) begin : g_bad_count
      $error("trig_delay_gen: NUM_CH must be at least 1");
   end
   if (CH_W < trig_pkg::trig_idx_w(NUM_CH)) begin : g_bad_idx
      $error("trig_delay_gen: CH_W too narrow for NUM_CH");
   end

   logic             fid_pulse;
   logic [CNT_W-1:0] cnt;

   trig_fid_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .fid_in    (fid_in),
      .fid_pulse (fid_pulse)
   );

   trig_counter #(.CNT_W(CNT_W)) i_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .fid_pulse (fid_pulse),
      .cnt_o     (cnt)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic hit;
      assign hit = cfg_we && (cfg_ch == CH_W'(g));

      trig_channel #(.CNT_W(CNT_W)) i_channel (
         .clk       (clk),
         .rst_n     (rst_n),
         .fid_pulse (fid_pulse),
         .cnt_i     (cnt),
         .wr_hit    (hit),
         .wr_start  (cfg_start),
         .wr_stop   (cfg_stop),
         .wr_en     (cfg_en),
         .trig_o    (trig_o[g])
      );
   end

   // R8: nothing fires while no marker has been seen since reset
   p_quiet_after_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!rst_n)) |-> (trig_o == '0));

endmodule

// File: tb/test_trig_delay_gen.sv
module test_trig_delay_gen;

   localparam int NCH  = 8;
   localparam int CW   = 24;
   localparam int NROW = 4;
   localparam int LEN  = 2600;

   localparam int T_START [NROW][NCH] = '{
      '{0,    2380, 10,  5,   30, 3,  1,    100},
      '{50,   0,    10,  5,   10, 3,  200,  7},
      '{1,    2,    3,   4,   5,  6,  7,    2000},
      '{2379, 0,    500, 600, 9,  12, 15,   18}};
   localparam int T_STOP [NROW][NCH] = '{
      '{119,  2499, 20,  5,   10, 60, 2,    219},
      '{60,   1,    20,  6,   30, 60, 2590, 7},
      '{2,    40,   90,  4,   119, 7, 8,    2119},
      '{2498, 119,  400, 719, 9,  13, 2596, 2380}};
   localparam bit T_EN [NROW][NCH] = '{
      '{1, 1, 1, 1, 1, 0, 1, 1},
      '{1, 1, 0, 1, 1, 1, 1, 1},
      '{1, 1, 1, 1, 0, 1, 1, 1},
      '{1, 0, 1, 1, 1, 1, 1, 1}};

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           fid_in = 1'b0;
   logic           cfg_we = 1'b0;
   logic [2:0]     cfg_ch = '0;
   logic [CW-1:0]  cfg_start = '0;
   logic [CW-1:0]  cfg_stop = '0;
   logic           cfg_en = 1'b0;
   logic [NCH-1:0] trig;

   logic           n_fid = 1'b0;
   logic           n_we = 1'b0;
   logic [0:0]     n_ch = '0;
   logic [7:0]     n_start = '0;
   logic [7:0]     n_stop = '0;
   logic           n_en = 1'b0;
   logic [1:0]     n_trig;

   int  n_checks = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   int  exp_start [NCH];
   int  exp_stop  [NCH];
   bit  exp_en    [NCH];

   always #10 clk = ~clk;

   trig_delay_gen i_trig_delay_gen (
      .clk(clk), .rst_n(rst_n), .fid_in(fid_in), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
      .cfg_start(cfg_start), .cfg_stop(cfg_stop), .cfg_en(cfg_en), .trig_o(trig));

   trig_delay_gen #(.NUM_CH(2), .CNT_W(8)) i_trig_delay_gen_narrow (
      .clk(clk), .rst_n(rst_n), .fid_in(n_fid), .cfg_we(n_we), .cfg_ch(n_ch),
      .cfg_start(n_start), .cfg_stop(n_stop), .cfg_en(n_en), .trig_o(n_trig));

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic string tag_of(input int s, input int p, input bit e);
      if (!e)                 return "R5";
      if (p <= s)             return "R4";
      if (s == 0 || s >= 2379) return "R9";
      return "R1_R3";
   endfunction

   function automatic bit expect_hi(input int ch, input int n);
      return exp_en[ch] && (exp_stop[ch] > exp_start[ch]) &&
             (n >= exp_start[ch] + 4) && (n < exp_stop[ch] + 4);
   endfunction

   task automatic write_ch(input int ch, input int s, input int p, input bit e);
      @(negedge clk);
      cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_start = CW'(s); cfg_stop = CW'(p); cfg_en = e;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic load_expect(input int row);
      for (int c = 0; c < NCH; c++) begin
         exp_start[c] = T_START[row][c];
         exp_stop[c]  = T_STOP[row][c];
         exp_en[c]    = T_EN[row][c];
      end
   endtask

   // One marker epoch; optionally writes row next_row into the holding copies
   // at cycles 5..12 while pulses of the current epoch are running (R6).
   task automatic run_epoch(input int len, input int hold, input int next_row,
                            input string extra);
      int mism [NCH];
      int first_n [NCH];
      int first_act [NCH];
      for (int c = 0; c < NCH; c++) begin
         mism[c] = 0; first_n[c] = -1; first_act[c] = 0;
      end
      @(negedge clk);
      fid_in = 1'b1;
      for (int n = 1; n <= len; n++) begin
         @(negedge clk);
         for (int c = 0; c < NCH; c++) begin
            if (trig[c] !== expect_hi(c, n)) begin
               if (mism[c] == 0) begin first_n[c] = n; first_act[c] = int'(trig[c]); end
               mism[c]++;
            end
         end
         fid_in = (n < hold);
         cfg_we = 1'b0;
         if (next_row >= 0 && n >= 5 && n < 5 + NCH) begin
            cfg_we = 1'b1; cfg_ch = 3'(n - 5);
            cfg_start = CW'(T_START[next_row][n-5]);
            cfg_stop  = CW'(T_STOP[next_row][n-5]);
            cfg_en    = T_EN[next_row][n-5];
         end
      end
      cfg_we = 1'b0;
      for (int c = 0; c < NCH; c++) begin
         check(mism[c] == 0, {tag_of(exp_start[c], exp_stop[c], exp_en[c]), extra},
               $sformatf("ch%0d start=%0d stop=%0d en=%0d level at edge %0d",
                         c, exp_start[c], exp_stop[c], exp_en[c], first_n[c]),
               first_act[c], 1 - first_act[c]);
      end
   endtask

   initial begin
      int rises0, rises1, hi0, hi1;
      bit prev0, prev1;

      repeat (3) @(negedge clk);
      // R8: outputs low in reset
      check(trig == '0, "R8", "outputs during reset", int'(trig), 0);
      rst_n = 1'b1;

      // R8: holding writes alone fire nothing before the first marker
      for (int c = 0; c < NCH; c++) write_ch(c, 1, 5, 1'b1);
      begin
         int seen = 0;
         for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            seen = seen | int'(trig);
         end
         check(seen == 0, "R8", "any output before first marker", seen, 0);
      end

      // Vector table walk; each next row written mid-epoch (R6)
      for (int r = 0; r < NROW; r++) write_ch(r, T_START[0][r], T_STOP[0][r], T_EN[0][r]);
      for (int r = NROW; r < NCH; r++) write_ch(r, T_START[0][r], T_STOP[0][r], T_EN[0][r]);
      for (int row = 0; row < NROW; row++) begin
         load_expect(row);
         run_epoch(LEN, 3, (row + 1 < NROW) ? row + 1 : -1,
                   (row > 0) ? " R6" : "");
      end

      // R2: marker held high 100 cycles restarts once
      write_ch(0, 60, 70, 1'b1);
      for (int c = 1; c < NCH; c++) write_ch(c, 0, 0, 1'b0);
      for (int c = 0; c < NCH; c++) begin exp_start[c] = 0; exp_stop[c] = 0; exp_en[c] = 0; end
      exp_start[0] = 60; exp_stop[0] = 70; exp_en[0] = 1;
      run_epoch(200, 100, -1, " R2");

      // R6: write with no marker afterwards leaves outputs unchanged
      write_ch(0, 0, 2000, 1'b1);
      begin
         int seen = 0;
         for (int n = 0; n < 30; n++) begin
            @(negedge clk);
            seen = seen | int'(trig);
         end
         check(seen == 0, "R6", "output after write without marker", seen, 0);
      end

      // R7: narrow counter saturates, each channel fires once
      @(negedge clk);
      n_we = 1'b1; n_ch = 1'b0; n_start = 8'd3;   n_stop = 8'd200; n_en = 1'b1;
      @(negedge clk);
      n_ch = 1'b1; n_start = 8'd250; n_stop = 8'd255; n_en = 1'b1;
      @(negedge clk);
      n_we = 1'b0;
      n_fid = 1'b1;
      rises0 = 0; rises1 = 0; hi0 = 0; hi1 = 0; prev0 = 1'b0; prev1 = 1'b0;
      for (int n = 1; n <= 900; n++) begin
         @(negedge clk);
         if (n == 3) n_fid = 1'b0;
         if (n_trig[0] && !prev0) rises0++;
         if (n_trig[1] && !prev1) rises1++;
         if (n_trig[0]) hi0++;
         if (n_trig[1]) hi1++;
         prev0 = n_trig[0];
         prev1 = n_trig[1];
      end
      check(rises0 == 1, "R7", "narrow ch0 pulse count", rises0, 1);
      check(hi0 == 197,  "R7", "narrow ch0 high cycles", hi0, 197);
      check(rises1 == 1, "R7", "narrow ch1 pulse count", rises1, 1);
      check(hi1 == 5,    "R7", "narrow ch1 high cycles ending at all-ones", hi1, 5);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule